// File: doc/BRIEF.md
# Asynchronous Serial Word Framer with Host Readout

This block sits behind a tone demodulator and takes its recovered bit stream, where a high level is the mark tone and a low level is the space tone. It also takes an active-low carrier-present flag. The carrier flag is stretched by a hold window, so a short signal dropout does not end reception. Until carrier has been seen, the line is ignored.

A mode input selects one of two paths. With `mode_buf` low, the raw line is copied straight to `data_out`. With `mode_buf` high, the block frames each asynchronous 8N1 character, discards the start bit, and parks the eight data bits and the stop bit in a nine-bit shift buffer. The host then pulls these bits out one per rising edge of its own read clock, data bits first (least significant first) and the stop bit last, so it can check the framing itself.

In both modes an active-low `ready_n` strobe marks the end of every word. In buffered mode, the first read-clock edge ends that strobe early, so reading the first bit also acknowledges the interrupt. A sticky overrun flag reports a word that was overwritten before the host read it.

Top module: `fsk_word_framer`

## Requirements
- R1: With `mode_buf` = 0, `data_out` equals `rx_bit` in the same cycle, with no register in the path.
- R2: A character starts when the line is low while carrier is present. The line is sampled again half a bit period (HALF = 8·TICK_CLKS clocks) after detection, and the start is dropped if the line is high there. The data bits follow, least significant first, each sampled one bit period (BIT = 16·TICK_CLKS clocks) after the previous sample. The stop bit is sampled one bit period after the last data bit.
- R3: In buffered mode, each synchronised rising edge of `rd_clk` puts the next buffered bit on `data_out`. The order is data bit 0 through data bit 7, then the stop bit as the ninth bit, whatever its value.
- R4: After the ninth read edge, further read edges leave `data_out` unchanged until the next word is loaded. After reset, the buffered `data_out` is 1.
- R5: In both modes, `ready_n` goes low one clock after the stop-bit sample and stays low for HALF clocks. Otherwise it is high.
- R6: In buffered mode, a read edge taken while `ready_n` is low returns `ready_n` high on that clock.
- R7: No character starts while carrier is absent, and a character in progress is abandoned when carrier is lost. Neither case produces a `ready_n` pulse.
- R8: Carrier counts as present from the clock after `carrier_n` is sampled low. It counts as lost only once `carrier_n` has stayed high for HOLD_BITS·BIT clocks.
- R9: In buffered mode, `overrun` is set when a word completes while the previous word has had no read edge. The new word replaces the old one. The first read edge after a load clears `overrun`. If a load and a read edge arrive on the same clock, the load wins.
- R10: While reset is held, `ready_n` = 1 and `overrun` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, a whole multiple of 16 times the bit rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_bit | input | 1 | Demodulated line, 1 = mark, 0 = space, synchronous to clk |
| carrier_n | input | 1 | Active-low carrier present, synchronous to clk |
| mode_buf | input | 1 | 0 = pass-through, 1 = buffered readout |
| rd_clk | input | 1 | Host read clock, asynchronous, synchronised inside the block |
| data_out | output | 1 | Raw line (mode 0) or the current buffered bit (mode 1) |
| ready_n | output | 1 | Active-low end-of-word strobe |
| overrun | output | 1 | Sticky flag: a word was overwritten before it was read |

## Verification
The assertions assume that `rx_bit` and `carrier_n` are already synchronous to `clk`. They also assume that `mode_buf` changes only while no character is in flight and the buffer is not being read, and that each `rd_clk` level lasts at least two clocks, so that the synchroniser sees every edge. The bench drives the line and the carrier on falling clock edges. It switches mode only between frames, holds each read-clock level for four clocks, and spaces false starts and carrier dropouts so that each one tests a single rule.

// File: rtl/fwf_pkg.sv
package fwf_pkg;

  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_DATA  = 2'd2,
    RX_STOP  = 2'd3
  } rx_state_e;

  // clocks in one bit period
  function automatic int bit_clks(input int oversample, input int tick_clks);
    return oversample * tick_clks;
  endfunction

  // clocks from a start edge to the start-bit midpoint; also the strobe width
  function automatic int half_clks(input int oversample, input int tick_clks);
    return (oversample * tick_clks) / 2;
  endfunction

  // clocks of continuous carrier absence before reception stops
  function automatic int hold_clks(input int hold_bits, input int oversample, input int tick_clks);
    return hold_bits * oversample * tick_clks;
  endfunction

endpackage

// File: rtl/fwf_carrier_hold.sv
module fwf_carrier_hold #(
  parameter int HOLD_CLKS = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic carrier_n,
  output logic carrier_ok
);
  localparam int CW = $clog2(HOLD_CLKS + 1);
  localparam logic [CW-1:0] GAP_LAST = CW'(HOLD_CLKS - 1);

  logic [CW-1:0] gap_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      carrier_ok <= 1'b0;
      gap_cnt    <= '0;
    end else if (!carrier_n) begin
      carrier_ok <= 1'b1;
      gap_cnt    <= '0;
    end else if (carrier_ok) begin
      if (gap_cnt == GAP_LAST) begin
        carrier_ok <= 1'b0;
        gap_cnt    <= '0;
      end else begin
        gap_cnt <= gap_cnt + 1'b1;
      end
    end
  end

  // R8: carrier is taken on the clock after it is seen
  a_r8_take_fast: assert property (@(posedge clk) disable iff (!rst_n)
    !carrier_n |=> carrier_ok);
  // R8: carrier is only dropped while the input reports absence
  a_r8_drop_only_absent: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(carrier_ok) |-> $past(carrier_n));

endmodule

// File: rtl/fwf_char_rx.sv
module fwf_char_rx
  import fwf_pkg::*;
#(
  parameter int BIT_CLKS  = 32,
  parameter int HALF_CLKS = 16,
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rx_bit,
  input  logic                 carrier_ok,
  output logic                 word_done,
  output logic [DATA_BITS:0]   word,
  output rx_state_e            state_o
);
  localparam int CW = $clog2(BIT_CLKS + 1);
  localparam int IW = $clog2(DATA_BITS + 1);
  localparam logic [CW-1:0] BIT_LAST  = CW'(BIT_CLKS - 1);
  localparam logic [CW-1:0] HALF_LAST = CW'(HALF_CLKS - 1);
  localparam logic [IW-1:0] IDX_LAST  = IW'(DATA_BITS - 1);

  rx_state_e            state;
  logic [CW-1:0]        cnt;
  logic [IW-1:0]        idx;
  logic [DATA_BITS-1:0] shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= RX_IDLE;
      cnt       <= '0;
      idx       <= '0;
      shreg     <= '0;
      word_done <= 1'b0;
      word      <= '1;
    end else begin
      word_done <= 1'b0;
      case (state)
        RX_IDLE: begin
          if (carrier_ok && !rx_bit) begin
            state <= RX_START;
            cnt   <= '0;
          end
        end
        RX_START: begin
          if (!carrier_ok) begin
            state <= RX_IDLE;
          end else if (cnt == HALF_LAST) begin
            cnt <= '0;
            idx <= '0;
            state <= rx_bit ? RX_IDLE : RX_DATA;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        RX_DATA: begin
          if (!carrier_ok) begin
            state <= RX_IDLE;
          end else if (cnt == BIT_LAST) begin
            cnt   <= '0;
            shreg <= {rx_bit, shreg[DATA_BITS-1:1]};
            if (idx == IDX_LAST) state <= RX_STOP;
            else idx <= idx + 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        RX_STOP: begin
          if (!carrier_ok) begin
            state <= RX_IDLE;
          end else if (cnt == BIT_LAST) begin
            word_done <= 1'b1;
            word      <= {rx_bit, shreg};
            state     <= RX_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= RX_IDLE;
      endcase
    end
  end

  assign state_o = state;

  // R7: losing carrier always returns the framer to idle
  a_r7_drop_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !carrier_ok |=> state == RX_IDLE);
  // R2: data phase is entered only after a low start midpoint
  a_r2_mid_start_low: assert property (@(posedge clk) disable iff (!rst_n)
    (state == RX_DATA && $past(state) == RX_START) |-> !$past(rx_bit));
  // R7: a word completes only with carrier present
  a_r7_done_with_carrier: assert property (@(posedge clk) disable iff (!rst_n)
    word_done |-> $past(carrier_ok));

endmodule

// File: rtl/fwf_readout.sv
module fwf_readout #(
  parameter int HALF_CLKS = 16,
  parameter int WORD_BITS = 9
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 mode_buf,
  input  logic                 rd_clk,
  input  logic                 word_done,
  input  logic [WORD_BITS-1:0] word,
  output logic                 buf_bit,
  output logic                 ready_n,
  output logic                 overrun
);
  localparam int RW = $clog2(WORD_BITS + 1);
  localparam int HW = $clog2(HALF_CLKS + 1);
  localparam logic [RW-1:0] RD_LAST   = RW'(WORD_BITS);
  localparam logic [HW-1:0] HALF_LAST = HW'(HALF_CLKS - 1);

  logic [2:0]           rd_sync;
  logic                 rd_rise;
  logic [WORD_BITS-1:0] shbuf;
  logic [RW-1:0]        rd_cnt;
  logic                 unread;
  logic                 dout;
  logic                 ovr_q;
  logic                 ready_lo;
  logic [HW-1:0]        rdy_cnt;
  logic                 take_read;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_sync <= '0;
    else        rd_sync <= {rd_sync[1:0], rd_clk};
  end

  assign rd_rise   = rd_sync[1] & ~rd_sync[2];
  assign take_read = mode_buf & rd_rise & ~word_done;

  // nine-bit buffer and shift-out
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shbuf  <= '1;
      rd_cnt <= RD_LAST;
      unread <= 1'b0;
      dout   <= 1'b1;
      ovr_q  <= 1'b0;
    end else if (word_done) begin
      shbuf  <= word;
      rd_cnt <= '0;
      unread <= 1'b1;
      if (unread && mode_buf) ovr_q <= 1'b1;
    end else if (take_read && rd_cnt != RD_LAST) begin
      dout   <= shbuf[0];
      shbuf  <= {1'b1, shbuf[WORD_BITS-1:1]};
      rd_cnt <= rd_cnt + 1'b1;
      unread <= 1'b0;
      if (rd_cnt == '0) ovr_q <= 1'b0;
    end
  end

  // end-of-word strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready_lo <= 1'b0;
      rdy_cnt  <= '0;
    end else if (word_done) begin
      ready_lo <= 1'b1;
      rdy_cnt  <= '0;
    end else if (ready_lo) begin
      if (take_read || rdy_cnt == HALF_LAST) ready_lo <= 1'b0;
      else rdy_cnt <= rdy_cnt + 1'b1;
    end
  end

  assign buf_bit = dout;
  assign ready_n = ~ready_lo;
  assign overrun = ovr_q;

  // R5: the strobe only opens right after a completed word
  a_r5_open_after_word: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_lo && !$past(ready_lo)) |-> $past(word_done));
  // R6: a read edge ends the strobe
  a_r6_read_releases: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_lo && take_read) |=> !ready_lo);
  // R3: a read edge presents the head of the buffer
  a_r3_next_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (take_read && rd_cnt != RD_LAST) |=> dout == $past(shbuf[0]));
  // R4: once drained, the output holds
  a_r4_hold_last: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_cnt == RD_LAST && !word_done) |=> $stable(dout));
  // R9: an unread word overwritten in buffered mode raises overrun
  a_r9_overrun_set: assert property (@(posedge clk) disable iff (!rst_n)
    (word_done && unread && mode_buf) |=> ovr_q);

endmodule

// File: rtl/fsk_word_framer.sv
module fsk_word_framer
  import fwf_pkg::*;
#(
  parameter int OVERSAMPLE = 16,
  parameter int TICK_CLKS  = 2,
  parameter int DATA_BITS  = 8,
  parameter int HOLD_BITS  = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_bit,
  input  logic carrier_n,
  input  logic mode_buf,
  input  logic rd_clk,
  output logic data_out,
  output logic ready_n,
  output logic overrun
);
  localparam int BIT_CLKS  = bit_clks(OVERSAMPLE, TICK_CLKS);
  localparam int HALF_CLKS = half_clks(OVERSAMPLE, TICK_CLKS);
  localparam int HOLD_CLKS = hold_clks(HOLD_BITS, OVERSAMPLE, TICK_CLKS);
  localparam int WORD_BITS = DATA_BITS + 1;

  logic                 carrier_ok;
  logic                 word_done;
  logic [WORD_BITS-1:0] word;
  logic                 buf_bit;
  rx_state_e            rx_state;

  fwf_carrier_hold #(.HOLD_CLKS(HOLD_CLKS)) u_carrier (
    .clk        (clk),
    .rst_n      (rst_n),
    .carrier_n  (carrier_n),
    .carrier_ok (carrier_ok)
  );

  fwf_char_rx #(
    .BIT_CLKS  (BIT_CLKS),
    .HALF_CLKS (HALF_CLKS),
    .DATA_BITS (DATA_BITS)
  ) u_rx (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_bit     (rx_bit),
    .carrier_ok (carrier_ok),
    .word_done  (word_done),
    .word       (word),
    .state_o    (rx_state)
  );

  fwf_readout #(
    .HALF_CLKS (HALF_CLKS),
    .WORD_BITS (WORD_BITS)
  ) u_readout (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_buf  (mode_buf),
    .rd_clk    (rd_clk),
    .word_done (word_done),
    .word      (word),
    .buf_bit   (buf_bit),
    .ready_n   (ready_n),
    .overrun   (overrun)
  );

  assign data_out = mode_buf ? buf_bit : rx_bit;

  // R10: reset values at the ports
  always_comb begin
    if (!rst_n) a_r10_reset_idle: assert (ready_n && !overrun);
  end

  // R7: no completed word without carrier having been present in the framer
  a_r7_idle_without_carrier: assert property (@(posedge clk) disable iff (!rst_n)
    (!carrier_ok && rx_state == RX_IDLE) |=> !word_done);

endmodule

// File: tb/fsk_word_framer_tb.sv
module fsk_word_framer_tb;
  localparam int OVS = 16;
  localparam int TCK = 2;
  localparam int HLD = 8;
  localparam int BITC  = OVS * TCK;
  localparam int HALFC = BITC / 2;
  localparam int HOLDC = HLD * BITC;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_bit = 1'b1;
  logic carrier_n = 1'b1;
  logic mode_buf = 1'b0;
  logic rd_clk = 1'b0;
  logic data_out, ready_n, overrun;

  int vectors = 0;
  int fails = 0;
  int ready_falls = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  fsk_word_framer #(.OVERSAMPLE(OVS), .TICK_CLKS(TCK), .DATA_BITS(8), .HOLD_BITS(HLD)) u_dut (
    .clk(clk), .rst_n(rst_n), .rx_bit(rx_bit), .carrier_n(carrier_n),
    .mode_buf(mode_buf), .rd_clk(rd_clk),
    .data_out(data_out), .ready_n(ready_n), .overrun(overrun)
  );

  // ---------------- behavioural reference model ----------------
  bit m_ok; int m_gap;
  int m_pos;                    // clocks since start detection, -1 when idle
  bit m_bits[9];
  bit m_word[9];
  bit m_pend;
  bit m_hist[3];
  int m_reads; bit m_unread; bit m_dout; bit m_ovr; int m_left;
  bit prev_rdy = 1'b1;

  task automatic check(input string tag, input logic act, input logic exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at %0t: actual %b expected %b", tag, $time, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ok = 0; m_gap = 0; m_pos = -1; m_pend = 0;
      foreach (m_hist[i]) m_hist[i] = 0;
      m_reads = 9; m_unread = 0; m_dout = 1; m_ovr = 0; m_left = 0;
    end else begin
      bit rise;
      rise = m_hist[1] && !m_hist[2];
      m_hist[2] = m_hist[1]; m_hist[1] = m_hist[0]; m_hist[0] = rd_clk;
      // readout side, reacting to the word finished one clock earlier
      if (m_pend) begin
        m_word = m_bits;
        m_reads = 0;
        if (m_unread && mode_buf) m_ovr = 1;
        m_unread = 1;
        m_left = HALFC;
      end else begin
        if (m_left > 0) begin
          if (mode_buf && rise) m_left = 0; else m_left--;
        end
        if (mode_buf && rise && m_reads < 9) begin
          m_dout = m_word[m_reads];
          if (m_reads == 0) m_ovr = 0;
          m_reads++;
          m_unread = 0;
        end
      end
      // framing side, using the carrier state from before this edge
      m_pend = 0;
      if (m_pos < 0) begin
        if (m_ok && !rx_bit) m_pos = 0;
      end else if (!m_ok) begin
        m_pos = -1;
      end else begin
        m_pos++;
        if (m_pos == HALFC) begin
          if (rx_bit) m_pos = -1;
        end else if (m_pos > HALFC && (m_pos - HALFC) % BITC == 0) begin
          int k;
          k = (m_pos - HALFC) / BITC;
          m_bits[k-1] = rx_bit;
          if (k == 9) begin m_pend = 1; m_pos = -1; end
        end
      end
      // carrier with hold window
      if (!carrier_n) begin m_ok = 1; m_gap = 0; end
      else if (m_ok) begin
        m_gap++;
        if (m_gap == HOLDC) begin m_ok = 0; m_gap = 0; end
      end
    end
    #3;
    if (rst_n && !finished) begin
      check("R1/R3/R4 data_out", data_out, mode_buf ? m_dout : rx_bit);
      check("R5/R6/R7 ready_n", ready_n, (m_left > 0) ? 1'b0 : 1'b1);
      check("R9 overrun", overrun, m_ovr);
      if (prev_rdy && !ready_n) ready_falls++;
      prev_rdy = ready_n;
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wait_clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] b, input logic stop_v);
    rx_bit = 1'b0; wait_clks(BITC);
    for (int i = 0; i < 8; i++) begin rx_bit = b[i]; wait_clks(BITC); end
    rx_bit = stop_v; wait_clks(BITC);
    rx_bit = 1'b1; wait_clks(BITC);
  endtask

  task automatic pulse_rd();
    rd_clk = 1'b1; wait_clks(4);
    rd_clk = 1'b0; wait_clks(4);
  endtask

  task automatic read_word(output logic [8:0] got);
    for (int i = 0; i < 9; i++) begin pulse_rd(); got[i] = data_out; end
  endtask

  task automatic check_word(input string tag, input logic [8:0] act, input logic [8:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check_int(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      fails++;
      $display("FAIL watchdog expired: actual running expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    logic [8:0] got;
    int falls0;
    wait_clks(4);
    // R10: reset state
    check("R10 ready_n in reset", ready_n, 1'b1);
    check("R10 overrun in reset", overrun, 1'b0);
    check("R1 data_out in reset", data_out, 1'b1);
    rst_n = 1'b1;
    wait_clks(4);

    // R7: no carrier, frame ignored
    mode_buf = 1'b1;
    send_frame(8'h96, 1'b1);
    check_int("R7 no word without carrier", ready_falls, 0);
    check("R4 buffered idle output", data_out, 1'b1);

    // R1 / R5: pass-through with carrier
    carrier_n = 1'b0; mode_buf = 1'b0; wait_clks(4);
    send_frame(8'h3C, 1'b1);
    check_int("R5 strobe in pass-through", ready_falls, 1);

    // R3 / R6: buffered read, starting while the strobe is low
    mode_buf = 1'b1; wait_clks(4);
    fork send_frame(8'hA5, 1'b1); join_none
    while (ready_n) @(negedge clk);
    pulse_rd();
    got[0] = data_out;
    check("R6 first read ends strobe", ready_n, 1'b1);
    for (int i = 1; i < 9; i++) begin pulse_rd(); got[i] = data_out; end
    wait fork;
    check_word("R3 buffered word A5", got, {1'b1, 8'hA5});
    check("R9 overrun cleared by read", overrun, 1'b0);
    pulse_rd();
    check("R4 tenth read holds stop bit", data_out, 1'b1);

    // R3: framing error visible as ninth bit
    send_frame(8'h5A, 1'b0);
    read_word(got);
    check_word("R3 stop bit zero read out", got, {1'b0, 8'h5A});

    // R2: false start rejected
    falls0 = ready_falls;
    rx_bit = 1'b0; wait_clks(4); rx_bit = 1'b1;
    wait_clks(12 * BITC);
    check_int("R2 false start dropped", ready_falls, falls0);

    // R9: overrun
    send_frame(8'h11, 1'b1);
    check("R9 no overrun after one word", overrun, 1'b0);
    send_frame(8'h22, 1'b1);
    check("R9 overrun after unread word", overrun, 1'b1);
    read_word(got);
    check("R9 overrun cleared", overrun, 1'b0);
    check_word("R9 newest word kept", got, {1'b1, 8'h22});

    // R8: short dropout inside a frame is bridged
    falls0 = ready_falls;
    fork
      send_frame(8'hC3, 1'b1);
      begin wait_clks(2 * BITC); carrier_n = 1'b1; wait_clks(3 * BITC); carrier_n = 1'b0; end
    join
    check_int("R8 word kept over short dropout", ready_falls, falls0 + 1);
    read_word(got);
    check_word("R8 word value", got, {1'b1, 8'hC3});

    // R7: long dropout aborts the frame in flight
    falls0 = ready_falls;
    fork
      send_frame(8'h0F, 1'b1);
      begin wait_clks(BITC); carrier_n = 1'b1; end
    join
    check_int("R7 frame abandoned on carrier loss", ready_falls, falls0);
    carrier_n = 1'b0;
    wait_clks(4);

    // R2 / R5: a last word after carrier returns
    send_frame(8'hE7, 1'b1);
    check_int("R5 strobe after recovery", ready_falls, falls0 + 1);
    read_word(got);
    check_word("R2 bit order LSB first", got, {1'b1, 8'hE7});

    wait_clks(4);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule